// File: doc/BRIEF.md
# Register-Driven Character Display Bus Port

This block gives a host processor direct, bit-level control of a parallel bus of the kind used by character display modules. The bus has an 8-bit bidirectional data path, a register-select line (low for instruction, high for data), a read/write line (low for write, high for read) and an active-high enable strobe. All of these are driven from a single 11-bit control word that the host writes at one I/O address. The block does not generate any bus timing of its own. Each edge on the display bus comes from a separate host write, so the order and spacing of those writes set the bus timing.

The read/write bit has two roles. When it is low, the block drives the low byte of the control word onto the data pins. When it is high, it releases the data pins so the display can drive them. A host read at the same address returns the data pins, sampled through a two-flop synchroniser, while the read/write bit is high. While that bit is low, a host read returns the control word's own low byte, and the block raises a flag that marks the read as not meaningful.

Top module: `lcdp_bus_port`

## Requirements
- R1: After reset the control word is all zeros: `lcd_rs`, `lcd_rw` and `lcd_en` are 0, `lcd_db_out` is 0 and `lcd_db_oe` is 1.
- R2: A write with `io_wr` high and `io_addr` equal to `PORT_ADDR` loads `io_wdata`. From the next clock edge, bits 7:0 appear on `lcd_db_out`, bit 8 on `lcd_rs`, bit 9 on `lcd_rw` and bit 10 on `lcd_en`.
- R3: A write to any other address leaves every bus output unchanged.
- R4: `lcd_db_oe` is 1 while the stored read/write bit (bit 9) is 0, and 0 while it is 1.
- R5: A host read at `PORT_ADDR` with bit 9 set returns the value of `lcd_db_in` from two clock edges earlier. A new input value is not visible after only one edge.
- R6: A host read at `PORT_ADDR` with bit 9 clear returns the stored bits 7:0 on `io_rdata` and drives `io_rd_invalid` high.
- R7: When no read hits `PORT_ADDR`, `io_rdata` is 0 and `io_rd_invalid` is 0.
- R8: A host read does not change the control word or any bus output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | ADDR_W | Host I/O address |
| io_wr | input | 1 | Host write strobe |
| io_rd | input | 1 | Host read strobe |
| io_wdata | input | 11 | Host write data (control word) |
| io_rdata | output | 8 | Host read data |
| io_rd_invalid | output | 1 | Read performed while the bus is in write mode |
| lcd_db_out | output | 8 | Data pin output value |
| lcd_db_oe | output | 1 | Data pin output enable (1 = drive) |
| lcd_db_in | input | 8 | Data pin input value |
| lcd_rs | output | 1 | Register select: 0 instruction, 1 data |
| lcd_rw | output | 1 | Direction: 0 write, 1 read |
| lcd_en | output | 1 | Enable strobe, active high |

## Verification
A table of control words is written in turn. The set includes words with only the enable bit set, only the select bit set, the read bit combined with data, and alternating data patterns. Together these tell apart any swap or loss of a bit between the word and the four bus outputs, and they show the output enable following the direction bit in both states. Directed sequences then write to a neighbouring address to show the write is ignored. They change the input pins and read one and two edges later to separate a correct two-stage synchroniser from a shorter or longer one. They also read in write mode to confirm the loopback value and the invalid flag, and show that reads and idle cycles leave the bus unchanged.

// File: rtl/lcdp_pkg.sv
package lcdp_pkg;
    localparam int LCD_DATA_W = 8;
    localparam int CTL_W      = LCD_DATA_W + 3;

    // Packed so that bit 10 = enable, 9 = direction, 8 = select, 7:0 = data
    typedef struct packed {
        logic                  en;
        logic                  rw;
        logic                  rs;
        logic [LCD_DATA_W-1:0] data;
    } lcd_ctl_t;
endpackage

// File: rtl/lcdp_ctrl_reg.sv
module lcdp_ctrl_reg
    import lcdp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic [CTL_W-1:0] wdata,
    output lcd_ctl_t         ctl
);
    typedef struct packed {
        lcd_ctl_t ctl;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_hit) begin
            st_d.ctl = lcd_ctl_t'(wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl = st_q.ctl;
endmodule

// File: rtl/lcdp_in_sync.sv
module lcdp_in_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stage;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stage[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d.stage[i] = st_q.stage[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.stage[STAGES-1];
endmodule

// File: rtl/lcdp_read_mux.sv
module lcdp_read_mux
    import lcdp_pkg::*;
(
    input  logic                  rd_hit,
    input  lcd_ctl_t              ctl,
    input  logic [LCD_DATA_W-1:0] pins_sync,
    output logic [LCD_DATA_W-1:0] rdata,
    output logic                  rd_invalid
);
    always_comb begin
        rdata      = '0;
        rd_invalid = 1'b0;
        if (rd_hit) begin
            if (ctl.rw) begin
                rdata = pins_sync;
            end else begin
                rdata      = ctl.data;
                rd_invalid = 1'b1;
            end
        end
    end
endmodule

// File: rtl/lcdp_bus_port.sv
module lcdp_bus_port
    import lcdp_pkg::*;
#(
    parameter int              ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 8'h0A,
    parameter int              SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     io_addr,
    input  logic                  io_wr,
    input  logic                  io_rd,
    input  logic [CTL_W-1:0]      io_wdata,
    output logic [LCD_DATA_W-1:0] io_rdata,
    output logic                  io_rd_invalid,
    output logic [LCD_DATA_W-1:0] lcd_db_out,
    output logic                  lcd_db_oe,
    input  logic [LCD_DATA_W-1:0] lcd_db_in,
    output logic                  lcd_rs,
    output logic                  lcd_rw,
    output logic                  lcd_en
);
    logic                  addr_hit;
    logic                  wr_hit;
    logic                  rd_hit;
    lcd_ctl_t              ctl;
    logic [LCD_DATA_W-1:0] pins_sync;

    assign addr_hit = (io_addr == PORT_ADDR);
    assign wr_hit   = addr_hit && io_wr;
    assign rd_hit   = addr_hit && io_rd;

    lcdp_ctrl_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_hit(wr_hit),
        .wdata (io_wdata),
        .ctl   (ctl)
    );

    lcdp_in_sync #(
        .WIDTH (LCD_DATA_W),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (lcd_db_in),
        .dout (pins_sync)
    );

    lcdp_read_mux u_rmux (
        .rd_hit    (rd_hit),
        .ctl       (ctl),
        .pins_sync (pins_sync),
        .rdata     (io_rdata),
        .rd_invalid(io_rd_invalid)
    );

    assign lcd_db_out = ctl.data;
    assign lcd_db_oe  = ~ctl.rw;
    assign lcd_rs     = ctl.rs;
    assign lcd_rw     = ctl.rw;
    assign lcd_en     = ctl.en;
endmodule

// File: rtl/lcdp_bus_port_chk.sv
module lcdp_bus_port_chk #(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 8'h0A
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_wr,
    input logic              io_rd,
    input logic [10:0]       io_wdata,
    input logic [7:0]        io_rdata,
    input logic              io_rd_invalid,
    input logic [7:0]        lcd_db_out,
    input logic              lcd_db_oe,
    input logic [7:0]        lcd_db_in,
    input logic              lcd_rs,
    input logic              lcd_rw,
    input logic              lcd_en
);
    logic [1:0]  age_q;
    logic [10:0] bus_word;

    assign bus_word = {lcd_en, lcd_rw, lcd_rs, lcd_db_out};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == PORT_ADDR) |=> bus_word == $past(io_wdata)); // R2

    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && io_addr == PORT_ADDR) |=> $stable(bus_word)); // R3

    AST_OE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_db_oe != lcd_rw); // R4

    AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && io_rd && io_addr == PORT_ADDR && lcd_rw)
            |-> io_rdata == $past(lcd_db_in, 2)); // R5

    AST_INVALID_LOOPBACK: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd_invalid |-> (io_rdata == lcd_db_out && !lcd_rw)); // R6

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rd && io_addr == PORT_ADDR) |-> (io_rdata == 8'h00 && !io_rd_invalid)); // R7
endmodule

bind lcdp_bus_port lcdp_bus_port_chk #(
    .ADDR_W   (ADDR_W),
    .PORT_ADDR(PORT_ADDR)
) u_chk (.*);

// File: tb/tb_lcdp_bus_port.sv
module tb_lcdp_bus_port;
    localparam logic [7:0] PA = 8'h0A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [10:0] io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        io_rd_invalid;
    logic [7:0]  lcd_db_out;
    logic        lcd_db_oe;
    logic [7:0]  lcd_db_in = '0;
    logic        lcd_rs, lcd_rw, lcd_en;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    lcdp_bus_port dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rd_invalid(io_rd_invalid),
        .lcd_db_out(lcd_db_out), .lcd_db_oe(lcd_db_oe), .lcd_db_in(lcd_db_in),
        .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_en(lcd_en)
    );

    // Control words written in turn: bit10 en, bit9 rw, bit8 rs, 7:0 data
    localparam int NVEC = 8;
    localparam logic [10:0] VEC [NVEC] = '{
        11'h400, 11'h100, 11'h0A5, 11'h15A,
        11'h2FF, 11'h633, 11'h5C3, 11'h7FF
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] a, input logic [10:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    function automatic logic [10:0] bus_now();
        return {lcd_en, lcd_rw, lcd_rs, lcd_db_out};
    endfunction

    initial begin
        #2_000_000;
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [10:0] held;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(bus_now() == 11'h000 && lcd_db_oe, "R1", {lcd_db_oe, bus_now()}, 12'h800);
        rst_n = 1'b1;
        @(negedge clk);
        check(bus_now() == 11'h000 && lcd_db_oe, "R1", {lcd_db_oe, bus_now()}, 12'h800);

        // Table walk: R2 load mapping, R4 output enable
        for (int i = 0; i < NVEC; i++) begin
            host_write(PA, VEC[i]);
            check(bus_now() == VEC[i], "R2", bus_now(), VEC[i]);
            check(lcd_db_oe == ~VEC[i][9], "R4", lcd_db_oe, ~VEC[i][9]);
        end

        // R3 write to other addresses ignored
        host_write(PA, 11'h1C3);
        host_write(8'h0B, 11'h7FF);
        check(bus_now() == 11'h1C3, "R3", bus_now(), 11'h1C3);
        host_write(8'h09, 11'h23C);
        check(bus_now() == 11'h1C3, "R3", bus_now(), 11'h1C3);

        // R6 read in write mode: loopback + invalid
        @(negedge clk); io_addr = PA; io_rd = 1'b1; #1;
        check(io_rdata == 8'hC3 && io_rd_invalid, "R6", {io_rd_invalid, io_rdata}, 9'h1C3);
        @(negedge clk); io_rd = 1'b0; #1;
        // R7 no read
        check(io_rdata == 8'h00 && !io_rd_invalid, "R7", {io_rd_invalid, io_rdata}, 9'h000);
        // R8 read left bus unchanged
        check(bus_now() == 11'h1C3, "R8", bus_now(), 11'h1C3);

        // R5 synchroniser latency, read mode
        host_write(PA, 11'h300);
        check(lcd_db_oe == 1'b0, "R4", lcd_db_oe, 1'b0);
        lcd_db_in = 8'h11;
        repeat (3) @(negedge clk);
        lcd_db_in = 8'h9E;
        io_rd = 1'b1;
        @(negedge clk); #1;
        check(io_rdata == 8'h11 && !io_rd_invalid, "R5", io_rdata, 8'h11);
        @(negedge clk); #1;
        check(io_rdata == 8'h9E && !io_rd_invalid, "R5", io_rdata, 8'h9E);
        // R7 read at wrong address
        io_addr = 8'h0C; #1;
        check(io_rdata == 8'h00 && !io_rd_invalid, "R7", {io_rd_invalid, io_rdata}, 9'h000);
        @(negedge clk); io_rd = 1'b0;
        // R8 repeated reads do not change the word
        held = bus_now();
        io_addr = PA;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); io_rd = 1'b1;
        end
        @(negedge clk); io_rd = 1'b0;
        check(bus_now() == held, "R8", bus_now(), held);

        // R1 reset again from non-zero state
        rst_n = 1'b0; #1;
        check(bus_now() == 11'h000 && lcd_db_oe, "R1", {lcd_db_oe, bus_now()}, 12'h800);
        @(negedge clk); rst_n = 1'b1;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule